// File: doc/BRIEF.md
# Register-Driven I2C Master Byte Engine

This block is a transmit-only I2C bus master worked through three small registers. A control register holds an enable bit and two request bits, one for a start and one for a stop. Each bus action is launched by a write to the transmit data register. That write produces one of three things: a start condition followed by the byte, a plain byte on a transaction that is already open, or a stop condition. A status pair reports whether the last action has finished and whether the slave acknowledged the last byte.

Software builds a page write as a chain of such writes. The first is a start carrying the device address, with the direction bit in bit 0 and 0 meaning write. Plain writes follow for the word address and each data word. A stop, launched by writing a don't-care value, ends the transfer. Before each launch, software polls the complete flag. SCL and SDA are open-drain: each output is an enable that pulls its line low. The quarter-period length of SCL is set in system clocks by a parameter.

Top module: `i2c_byte_master`

## Requirements
- R1: Out of reset, `ctl_q` is 0, `op_done` is 1, `slave_acked` is 0 and neither line is pulled. `ctl_q` bit 0 is the enable, bit 1 the start request and bit 2 the stop request, and `ctl_wr` loads all three from `ctl_wdata`.
- R2: A data write with enable and start set produces a start condition (SDA falls while SCL is high) and then sends the byte MSB first. SDA is released for a ninth acknowledge clock. SCL is then held low, and the action takes 40*QDIV cycles from the write to `op_done`.
- R3: A data write that launches an action clears the start and stop request bits in the next cycle and keeps the enable bit.
- R4: A data write with enable set and neither request set sends the byte with no start or stop condition, in 36*QDIV cycles.
- R5: A data write with enable and stop set (start clear) ignores the data and produces a stop condition (SDA rises while SCL is high). It then releases both lines, in 4*QDIV cycles.
- R6: `op_done` falls in the cycle after a launching write, stays low while the engine is busy, and rises once the action ends.
- R7: `slave_acked` is cleared by a launching write. It becomes 1 when SDA is low during the high phase of the ninth clock of a byte, and stays 0 when SDA is high there.
- R8: A data write while the engine is busy is ignored: the running byte is unchanged and no further action follows.
- R9: A data write while the enable bit is clear causes no bus activity and leaves `ctl_q`, `op_done` and `slave_acked` unchanged.
- R10: With both start and stop requested, a data write produces the start-plus-byte action and clears both request bits.
- R11: SDA changes while SCL is high only inside a start condition (falling) or a stop condition (rising).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control value: bit 2 stop request, bit 1 start request, bit 0 enable |
| ctl_q | output | 3 | Control register contents |
| txd_wr | input | 1 | Transmit data register write strobe; launches an action |
| txd_wdata | input | 8 | Byte to send (ignored for a stop) |
| op_done | output | 1 | Complete flag |
| slave_acked | output | 1 | Acknowledge-in flag of the last byte |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong phase or bit index in the sequencer shows on the bus within one SCL period. It appears as a misplaced SDA edge while SCL is high, a shifted or missing bit in the byte a bus monitor rebuilds, or an action whose length is not 4, 36 or 40 quarter periods. A wrong launch or request decode shows one cycle after the data write, in `ctl_q` or `op_done`. A wrong acknowledge sample shows in `slave_acked` at the end of the byte. Stray activity after an ignored write shows as an extra byte or edge counted by the monitor before the next launch.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W + 1);
  localparam int ACK_SLOT = BYTE_W;

  typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_BITS, SQ_STOP} seq_e;
  typedef enum logic [1:0] {ACT_START, ACT_BYTE, ACT_STOP} act_e;

  // start has priority over stop; neither means a plain byte
  function automatic act_e pick_act(input logic start_rq, input logic stop_rq);
    if (start_rq)     return ACT_START;
    else if (stop_rq) return ACT_STOP;
    else              return ACT_BYTE;
  endfunction

  // quarter-phase SCL pull-down
  function automatic logic scl_pull(input seq_e st, input logic [1:0] q, input logic held);
    case (st)
      SQ_START: return (q == 2'd3);
      SQ_BITS:  return (q == 2'd0) || (q == 2'd3);
      SQ_STOP:  return (q == 2'd0);
      default:  return held;
    endcase
  endfunction

  // quarter-phase SDA pull-down
  function automatic logic sda_pull(input seq_e st, input logic [1:0] q,
                                    input logic [IDX_W-1:0] idx, input logic msb);
    case (st)
      SQ_START: return (q != 2'd0);
      SQ_BITS:  return (idx == IDX_W'(ACK_SLOT)) ? 1'b0 : ~msb;
      SQ_STOP:  return (q < 2'd2);
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2c_bm_qtimer.sv
module i2c_bm_qtimer #(
  parameter int QDIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_bm_seq.sv
module i2c_bm_seq
  import i2c_bm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  act_e              act,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              tick,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              op_end,
  output logic              ack_stb,
  output logic              ack_val,
  output logic              in_start,
  output logic              in_stop
);
  seq_e              st;
  logic [1:0]        q;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] shreg;
  logic              held;

  logic at_ack, q_last;
  assign at_ack   = (st == SQ_BITS) && (idx == IDX_W'(ACK_SLOT));
  assign q_last   = tick && (q == 2'd3);
  assign busy     = (st != SQ_IDLE);
  assign in_start = (st == SQ_START);
  assign in_stop  = (st == SQ_STOP);
  assign op_end   = q_last && (at_ack || st == SQ_STOP);
  assign ack_stb  = tick && at_ack && (q == 2'd1);
  assign ack_val  = ~sda_in;
  assign scl_oe   = scl_pull(st, q, held);
  assign sda_oe   = sda_pull(st, q, idx, shreg[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; q <= '0; idx <= '0; shreg <= '0; held <= 1'b0;
    end else if (st == SQ_IDLE) begin
      if (go) begin
        shreg <= byte_in;
        q     <= '0;
        idx   <= '0;
        case (act)
          ACT_START: st <= SQ_START;
          ACT_STOP:  st <= SQ_STOP;
          default:   st <= SQ_BITS;
        endcase
      end
    end else if (tick) begin
      q <= q + 2'd1;
      if (q == 2'd3) begin
        case (st)
          SQ_START: begin st <= SQ_BITS; held <= 1'b1; end
          SQ_BITS:
            if (at_ack) st <= SQ_IDLE;
            else begin
              idx   <= idx + 1'b1;
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
          SQ_STOP:  begin st <= SQ_IDLE; held <= 1'b0; end
          default:  st <= SQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int QDIV = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  output logic [2:0]        ctl_q,
  input  logic              txd_wr,
  input  logic [BYTE_W-1:0] txd_wdata,
  output logic              op_done,
  output logic              slave_acked,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  logic en_q, start_q, stop_q, done_q, ack_q;
  logic busy, launch, tick, op_end, ack_stb, ack_val, in_start, in_stop;
  act_e act;

  assign act    = pick_act(start_q, stop_q);
  assign launch = txd_wr && !busy && en_q;

  i2c_bm_qtimer #(.QDIV(QDIV)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  i2c_bm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(launch), .act(act), .byte_in(txd_wdata),
    .tick(tick), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .op_end(op_end), .ack_stb(ack_stb), .ack_val(ack_val),
    .in_start(in_start), .in_stop(in_stop)
  );

  // control register: a launch clears the requests and wins over a same-cycle write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; start_q <= 1'b0; stop_q <= 1'b0;
    end else if (launch) begin
      start_q <= 1'b0; stop_q <= 1'b0;
    end else if (ctl_wr) begin
      {stop_q, start_q, en_q} <= ctl_wdata;
    end
  end

  // status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1; ack_q <= 1'b0;
    end else if (launch) begin
      done_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      if (ack_stb) ack_q  <= ack_val;
      if (op_end)  done_q <= 1'b1;
    end
  end

  assign ctl_q       = {stop_q, start_q, en_q};
  assign op_done     = done_q;
  assign slave_acked = ack_q;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [2:0] ctl_q,
  input logic       txd_wr,
  input logic       op_done,
  input logic       slave_acked,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic       launch,
  input logic       op_end,
  input logic       ack_stb,
  input logic       in_start,
  input logic       in_stop
);
  // R6
  done_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_done);

  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_end |=> (op_done && !busy));

  // R3
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (ctl_q[2:1] == 2'b00 && ctl_q[0]));

  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && busy && !ctl_wr) |=> $stable(ctl_q));

  // R9
  disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_wr && !busy && !ctl_q[0] && !ctl_wr) |=>
      (!busy && $stable(op_done) && $stable(slave_acked) && $stable(ctl_q)));

  // R11
  sda_fall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe && !$past(sda_oe)) |-> in_start);

  // R11
  sda_rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !sda_oe && $past(sda_oe)) |-> in_stop);

  // R7
  ack_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slave_acked) |-> $past(ack_stb || launch));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_q(ctl_q), .txd_wr(txd_wr),
  .op_done(op_done), .slave_acked(slave_acked), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .launch(launch), .op_end(op_end), .ack_stb(ack_stb),
  .in_start(in_start), .in_stop(in_stop)
);

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  localparam int Q = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 1'b0, txd_wr = 1'b0;
  logic [2:0] ctl_wdata = '0, ctl_q;
  logic [7:0] txd_wdata = '0;
  logic op_done, slave_acked, scl_oe, sda_oe, sda_in;

  // bus model
  logic slave_pull = 1'b0, ack_en = 1'b0;
  logic scl_line, sda_line, p_scl = 1'b1, p_sda = 1'b1;
  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slave_pull);
  assign sda_in   = sda_line;

  int starts = 0, stops = 0, bytes = 0, bitcnt = 0;
  logic [7:0] mon_sh = '0, mon_byte = '0;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_byte_master #(.QDIV(Q)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .txd_wr(txd_wr), .txd_wdata(txd_wdata), .op_done(op_done),
    .slave_acked(slave_acked), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // slave-side monitor, away from the active edge
  always @(negedge clk) begin
    if (p_scl && scl_line && p_sda && !sda_line) begin starts++; bitcnt = 0; end
    if (p_scl && scl_line && !p_sda && sda_line) stops++;
    if (!p_scl && scl_line) begin
      if (bitcnt < 8) mon_sh = {mon_sh[6:0], sda_line};
      bitcnt++;
    end
    if (p_scl && !scl_line) begin
      if (bitcnt == 8) slave_pull = ack_en;
      else if (bitcnt == 9) begin
        slave_pull = 1'b0; bytes++; mon_byte = mon_sh; bitcnt = 0;
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  function automatic int exp_cycles(input logic st, input logic sp);
    if (st)      return 40 * Q;
    else if (sp) return 4 * Q;
    else         return 36 * Q;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [2:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic write_txd(input logic [7:0] d);
    @(negedge clk); txd_wdata = d; txd_wr = 1'b1;
    @(negedge clk); txd_wr = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!op_done && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int cyc, b0, s0, p0;
    logic [7:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctl_q == 3'b000, "R1 ctl reset", ctl_q, 0);
    chk(op_done == 1'b1, "R1 done reset", op_done, 1);
    chk(slave_acked == 1'b0, "R1 ack reset", slave_acked, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    write_ctl(3'b010);
    chk(ctl_q == 3'b010, "R1 ctl load", ctl_q, 2);

    // R9 disabled write
    write_txd(8'hA0);
    repeat (60) @(negedge clk);
    chk(starts == 0 && bytes == 0, "R9 no bus activity", starts + bytes, 0);
    chk(op_done == 1'b1, "R9 done unchanged", op_done, 1);
    chk(ctl_q == 3'b010, "R9 ctl unchanged", ctl_q, 2);

    // R2 start + address, with R3/R6/R8
    ack_en = 1'b1;
    d = {7'($urandom), 1'b0};
    write_ctl(3'b011);
    write_txd(d);
    chk(op_done == 1'b0, "R6 done cleared", op_done, 0);
    chk(ctl_q == 3'b001, "R3 requests cleared", ctl_q, 1);
    write_txd(~d);  // R8 ignored while busy
    wait_done(cyc);
    chk(cyc == exp_cycles(1, 0) - 2, "R2 start duration", cyc, exp_cycles(1, 0) - 2);
    chk(starts == 1 && bytes == 1, "R2 start and one byte", starts * 10 + bytes, 11);
    chk(mon_byte == d, "R2 address byte MSB first", mon_byte, d);
    chk(slave_acked == 1'b1, "R7 ack seen", slave_acked, 1);
    chk(scl_oe == 1'b1, "R2 SCL held low", scl_oe, 1);
    repeat (60) @(negedge clk);
    chk(bytes == 1 && op_done, "R8 busy write dropped", bytes, 1);

    // R4 random data bytes, R7 random acknowledge
    for (int i = 0; i < 20; i++) begin
      d = 8'($urandom);
      ack_en = 1'($urandom);
      b0 = bytes; s0 = starts;
      write_txd(d);
      wait_done(cyc);
      chk(cyc == exp_cycles(0, 0), "R4 byte duration", cyc, exp_cycles(0, 0));
      chk(mon_byte == d && bytes == b0 + 1, "R4 byte data", mon_byte, d);
      chk(starts == s0 && stops == 0, "R4 no start or stop", starts - s0 + stops, 0);
      chk(slave_acked == ack_en, "R7 ack flag", slave_acked, ack_en);
    end

    // R9 enable clear keeps status after an acked byte
    ack_en = 1'b1;
    write_txd(8'h3C);
    wait_done(cyc);
    write_ctl(3'b100);
    b0 = bytes;
    write_txd(8'hFF);
    repeat (40) @(negedge clk);
    chk(slave_acked == 1'b1 && op_done, "R9 status kept", slave_acked, 1);
    chk(bytes == b0 && stops == 0 && ctl_q == 3'b100, "R9 nothing sent", ctl_q, 4);

    // R5 stop with dummy data
    write_ctl(3'b101);
    b0 = bytes;
    write_txd(8'($urandom));
    wait_done(cyc);
    chk(cyc == exp_cycles(0, 1), "R5 stop duration", cyc, exp_cycles(0, 1));
    chk(stops == 1 && bytes == b0, "R5 stop only", stops, 1);
    chk(!scl_oe && !sda_oe, "R5 lines released", {scl_oe, sda_oe}, 0);
    chk(ctl_q == 3'b001, "R3 stop request cleared", ctl_q, 1);

    // R10 both requests: start wins
    ack_en = 1'b0;
    s0 = starts; p0 = stops;
    d = 8'hA1;
    write_ctl(3'b111);
    write_txd(d);
    chk(ctl_q == 3'b001, "R10 both cleared", ctl_q, 1);
    wait_done(cyc);
    chk(starts == s0 + 1 && stops == p0, "R10 start chosen", starts - s0, 1);
    chk(mon_byte == d, "R10 byte", mon_byte, d);
    chk(slave_acked == 1'b0, "R7 no ack", slave_acked, 0);
    write_ctl(3'b101);
    write_txd(8'h00);
    wait_done(cyc);
    chk(stops == p0 + 1, "R5 second stop", stops, p0 + 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule